// File: doc/BRIEF.md
# Receive Descriptor Buffer Sequencer

This block steps through a list of receive descriptors in memory for an Ethernet receive DMA engine. A `start` pulse points it at the list base, and it asks for a descriptor fetch. When the four fetched words arrive, it decodes the control word and grants the data buffers one at a time. Each grant carries a word-aligned write address, a byte count and, for the buffer that opens a frame, the byte offset of the true pointer.

When the descriptor is finished, it raises a one-cycle completion interrupt unless the descriptor masks it. It then computes where the next descriptor lives and requests that fetch. Two list layouts are supported. In the ring layout, descriptors sit at a fixed stride and the list wraps to the base at the flagged last entry. In the chained layout, the second pointer is the link to the next descriptor. Moving frame data and writing status back are done elsewhere.

Top module: `rx_desc_walker`

## Requirements
- R1: After reset, `fetch_req`, `buf_valid`, `irq` and `chain_err` are low. One cycle after a `start` pulse, `fetch_req` is high with `fetch_addr` equal to `list_base`, and it stays high until `desc_valid`.
- R2: The buffer 1 byte count is control bits [12:0] and the buffer 2 byte count is control bits [28:16]. Control bits [30:29] and [13] have no effect on any output.
- R3: Buffer 1 is granted before buffer 2. Each grant holds `buf_valid`, `buf_addr`, `buf_len` and `buf_offset` steady until `buf_full` or `frame_done`. The next grant, or the completion cycle, follows one cycle later.
- R4: A buffer 1 count of zero skips buffer 1. The sequencer goes to buffer 2, or straight to completion when chaining is set or buffer 2 is also empty. A grant never has `buf_len` of zero.
- R5: When control bit 14 (chained) is set, no buffer 2 grant is made and the buffer 2 count is ignored. Unless bit 15 is also set, the next fetch address is the fourth descriptor word.
- R6: In ring mode (bit 14 clear, bit 15 clear), the next fetch address is the current one plus 32. A buffer 2 count of zero skips buffer 2.
- R7: When control bit 15 (end of ring) is set, the next fetch address is `list_base`, even when bit 14 is also set.
- R8: Completion is one cycle after the last grant is released, or one cycle after `desc_valid` when no buffer is granted. In that cycle `irq` is high for exactly one cycle if control bit 31 is clear, and stays low if bit 31 is set. `fetch_req` follows in the next cycle.
- R9: `frame_done` during a grant ends the descriptor at once, with no further buffer grant. The next granted buffer then opens a new frame.
- R10: `buf_addr[1:0]` is always zero. For a buffer that opens a frame, `buf_offset` equals the pointer's low two bits. For any other buffer, `buf_offset` is zero. A frame opens at the first grant after `start` or after `frame_done`.
- R11: In the completion cycle, `chain_err` is high exactly when bit 14 is set, bit 15 is clear, and the fourth word's low two bits are not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin walking at `list_base` (from idle) |
| list_base | input | 32 | Address of the first descriptor |
| fetch_req | output | 1 | Descriptor fetch request |
| fetch_addr | output | 32 | Address of the descriptor to fetch |
| desc_valid | input | 1 | Fetched descriptor words are present |
| desc_ctl | input | 32 | Descriptor control word |
| desc_ptr1 | input | 32 | Buffer 1 pointer |
| desc_ptr2 | input | 32 | Buffer 2 pointer or next-descriptor link |
| buf_valid | output | 1 | A buffer grant is active |
| buf_addr | output | 32 | Word-aligned buffer write address |
| buf_len | output | 13 | Buffer byte count |
| buf_offset | output | 2 | Data byte offset for a frame-opening buffer |
| buf_full | input | 1 | Current buffer consumed |
| frame_done | input | 1 | Frame ended; finish this descriptor |
| irq | output | 1 | Completion interrupt pulse |
| chain_err | output | 1 | Misaligned chained link seen at completion |

## Verification
Directed descriptors first try each flag alone and in pairs:
- both buffers filled in ring mode;
- an empty buffer 1;
- a chained link;
- end of ring together with chaining, which shows which flag wins;
- a masked interrupt with an empty buffer 2;
- an early frame end;
- a misaligned link;
- a descriptor with no buffers at all.

Random descriptors with random reserved bits, pointers and flags then mix in early frame ends and hold stalls. These show whether reserved bits leak into the outputs, whether the frame-opening offset follows `frame_done` across descriptors, and whether the walk address stays correct through many ring wraps and chain jumps.

// File: rtl/rx_desc_walker.sv
module rx_desc_walker #(
  parameter int STRIDE = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] list_base,
  output logic        fetch_req,
  output logic [31:0] fetch_addr,
  input  logic        desc_valid,
  input  logic [31:0] desc_ctl,
  input  logic [31:0] desc_ptr1,
  input  logic [31:0] desc_ptr2,
  output logic        buf_valid,
  output logic [31:0] buf_addr,
  output logic [12:0] buf_len,
  output logic [1:0]  buf_offset,
  input  logic        buf_full,
  input  logic        frame_done,
  output logic        irq,
  output logic        chain_err
);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_BUF1, S_BUF2, S_DONE} st_t;

  st_t         st;
  logic [31:0] cur, ctl, p1, p2;
  logic        sof;

  wire        eor  = ctl[15];
  wire        chn  = ctl[14];
  wire [12:0] len1 = ctl[12:0];
  wire [12:0] len2 = ctl[28:16];
  wire        use2 = !chn && (len2 != 13'd0);
  wire        in_use2 = !desc_ctl[14] && (desc_ctl[28:16] != 13'd0);
  wire [31:0] nxt  = eor ? list_base : (chn ? p2 : cur + 32'(STRIDE));
  wire [31:0] bptr = (st == S_BUF2) ? p2 : p1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cur <= '0;
      ctl <= '0;
      p1  <= '0;
      p2  <= '0;
      sof <= 1'b1;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          cur <= list_base;
          sof <= 1'b1;
          st  <= S_FETCH;
        end
        S_FETCH: if (desc_valid) begin
          ctl <= desc_ctl;
          p1  <= desc_ptr1;
          p2  <= desc_ptr2;
          if (desc_ctl[12:0] != 13'd0) st <= S_BUF1;
          else if (in_use2)            st <= S_BUF2;
          else                         st <= S_DONE;
        end
        S_BUF1: if (frame_done) begin
          sof <= 1'b1;
          st  <= S_DONE;
        end else if (buf_full) begin
          sof <= 1'b0;
          st  <= use2 ? S_BUF2 : S_DONE;
        end
        S_BUF2: if (frame_done) begin
          sof <= 1'b1;
          st  <= S_DONE;
        end else if (buf_full) begin
          sof <= 1'b0;
          st  <= S_DONE;
        end
        S_DONE: begin
          cur <= nxt;
          st  <= S_FETCH;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign fetch_req  = (st == S_FETCH);
  assign fetch_addr = cur;
  assign buf_valid  = (st == S_BUF1) || (st == S_BUF2);
  assign buf_addr   = {bptr[31:2], 2'b00};
  assign buf_len    = (st == S_BUF2) ? len2 : len1;
  assign buf_offset = sof ? bptr[1:0] : 2'b00;
  assign irq        = (st == S_DONE) && !ctl[31];
  assign chain_err  = (st == S_DONE) && chn && !eor && (p2[1:0] != 2'b00);

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !desc_valid) |=> fetch_req && $stable(fetch_addr));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_valid && !buf_full && !frame_done) |=>
      buf_valid && $stable(buf_addr) && $stable(buf_len) && $stable(buf_offset));

  assert_nonzero_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid |-> buf_len != 13'd0);

  assert_chain_link_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE && chn && !eor) |=> fetch_req && fetch_addr == $past(p2));

  assert_eor_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE && eor) |=> fetch_req && fetch_addr == $past(list_base));

  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq && fetch_req);

  assert_early_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_valid && frame_done) |=> !buf_valid);

  assert_mid_offset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_valid && buf_full && !frame_done) |=> !buf_valid || buf_offset == 2'b00);

endmodule

// File: tb/test_rx_desc_walker.sv
module test_rx_desc_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] list_base = 32'h2000_0000;
  logic        fetch_req;
  logic [31:0] fetch_addr;
  logic        desc_valid = 1'b0;
  logic [31:0] desc_ctl = '0, desc_ptr1 = '0, desc_ptr2 = '0;
  logic        buf_valid;
  logic [31:0] buf_addr;
  logic [12:0] buf_len;
  logic [1:0]  buf_offset;
  logic        buf_full = 1'b0, frame_done = 1'b0;
  logic        irq, chain_err;

  always #2.5 clk = ~clk;

  rx_desc_walker i_rx_desc_walker (.*);

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] exp_addr;
  bit exp_sof;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] grant_word(input logic [31:0] a, input logic [12:0] l, input logic [1:0] o);
    return {15'd0, a, l, o, 2'b00};
  endfunction

  function automatic logic [31:0] next_of(input logic [31:0] c, input logic [31:0] a2, input logic [31:0] here);
    return c[15] ? list_base : (c[14] ? a2 : here + 32'd32);
  endfunction

  task automatic take_buf(input logic [31:0] a, input logic [12:0] l, input bit end_frame,
                          input int stall, input string tag);
    logic [63:0] e;
    e = grant_word({a[31:2], 2'b00}, l, exp_sof ? a[1:0] : 2'b00);
    for (int s = 0; s <= stall; s++) begin
      check(buf_valid && grant_word(buf_addr, buf_len, buf_offset) == e, tag,
            grant_word(buf_addr, buf_len, buf_offset), e);
      if (s < stall) @(negedge clk);
    end
    if (end_frame) frame_done = 1'b1; else buf_full = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
    buf_full = 1'b0;
    exp_sof = end_frame;
  endtask

  task automatic do_desc(input logic [31:0] c, input logic [31:0] a1, input logic [31:0] a2,
                         input int fd_at, input int stall);
    bit has1, has2, ended;
    check(fetch_req && fetch_addr == exp_addr, "R6 R5 R7 fetch address", {31'd0, fetch_req, fetch_addr},
          {31'd0, 1'b1, exp_addr});
    desc_valid = 1'b1; desc_ctl = c; desc_ptr1 = a1; desc_ptr2 = a2;
    @(negedge clk);
    desc_valid = 1'b0;
    has1 = c[12:0] != 13'd0;
    has2 = !c[14] && c[28:16] != 13'd0;
    ended = 0;
    if (has1) begin
      take_buf(a1, c[12:0], fd_at == 1, stall, "R2 R3 R10 buffer 1 grant");
      ended = (fd_at == 1);
    end
    if (has2 && !ended)
      take_buf(a2, c[28:16], fd_at == 2, stall, "R2 R3 R4 R10 buffer 2 grant");
    check(!buf_valid, "R4 R5 R6 R9 no extra grant", {63'd0, buf_valid}, 64'd0);
    check(irq == !c[31], "R8 completion irq", {63'd0, irq}, {63'd0, !c[31]});
    check(chain_err == (c[14] && !c[15] && a2[1:0] != 2'b00), "R11 chain error",
          {63'd0, chain_err}, {63'd0, (c[14] && !c[15] && a2[1:0] != 2'b00)});
    exp_addr = next_of(c, a2, exp_addr);
    @(negedge clk);
    check(!irq, "R8 irq single pulse", {63'd0, irq}, 64'd0);
  endtask

  initial begin
    logic [31:0] c, a1, a2;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(!fetch_req && !buf_valid && !irq && !chain_err, "R1 reset state",
          {60'd0, fetch_req, buf_valid, irq, chain_err}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!fetch_req, "R1 idle before start", {63'd0, fetch_req}, 64'd0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    exp_addr = list_base;
    exp_sof = 1;
    do_desc(32'h6040_2040 | 32'h0080_0000, 32'h1000_0103, 32'h1100_0002, 0, 1);
    do_desc({3'b0, 13'd40, 16'h0000}, 32'h1200_0000, 32'h1300_0001, 0, 0);
    do_desc({3'b0, 13'd100, 2'b01, 14'd16}, 32'h1400_0002, 32'h3000_0040, 0, 0);
    do_desc({3'b0, 13'd7, 2'b11, 14'd8}, 32'h1500_0001, 32'h4000_0000, 0, 2);
    do_desc({1'b1, 2'b0, 13'd0, 2'b00, 14'd12}, 32'h1600_0003, 32'h1700_0000, 0, 0);
    do_desc({3'b0, 13'd24, 2'b00, 14'd20}, 32'h1800_0001, 32'h1900_0000, 1, 0);
    do_desc({3'b0, 13'd0, 2'b01, 14'd32}, 32'h1a00_0002, 32'h5000_0082, 0, 0);
    do_desc({3'b0, 13'd0, 2'b01, 14'd0}, 32'h1b00_0000, 32'h5100_0000, 0, 0);
    do_desc({3'b0, 13'd0, 2'b00, 14'd0}, 32'h1c00_0000, 32'h1d00_0000, 0, 0);
    for (int i = 0; i < 300; i++) begin
      c = $urandom;
      if ($urandom % 4 == 0) c[12:0] = 13'd0;
      if ($urandom % 4 == 0) c[28:16] = 13'd0;
      c[15] = ($urandom % 8 == 0);
      a1 = $urandom;
      a2 = $urandom;
      if (c[14] && ($urandom % 4 != 0)) a2[1:0] = 2'b00;
      do_desc(c, a1, a2, int'($urandom % 4), int'($urandom % 3));
    end
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule